// File: doc/BRIEF.md
# SPI Register Access Port

This block is an SPI target (slave) that lets an external host read and write a bank of up to 64 registers, 24 bits each, inside a peripheral controller. Each transaction is one 32-bit word framed by an active-high select. The block decodes the direction flag, the register address and the payload, and drives a plain internal register bus with an address, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data return.

The host clock, select and data-in pins are brought into the system clock domain through a two-stage synchroniser, and all edges are detected there. The bus runs in mode 0: the host samples on rising SCK and both sides change data on falling SCK. On a read frame the addressed register is fetched as soon as the address bits are in, and its 24 bits are shifted out in the low part of the same frame. A write is committed only after a complete 32-bit frame has arrived and select has dropped.

The register side has no back-pressure, so the stream-style handshake is replaced by fixed timing. `reg_rdata` must be valid, combinationally from `reg_addr`, in the cycle `reg_rd` is high. The register file must accept a write in the cycle `reg_wr` is high.

Top module: `spi_regport`

## Requirements
- R1: A frame is 32 bits, most significant bit first. Bit 31 is the direction, where 1 means write and 0 means read. Bits 30..25 are the register address, bit 24 is ignored, and bits 23..0 are the write payload. A write frame of exactly 32 bits writes the payload to that address.
- R2: `reg_wr` is a single-cycle pulse issued only after select falls, one per complete write frame. `reg_addr` and `reg_wdata` carry the frame's address and payload in that cycle.
- R3: A frame that ends with any bit count other than 32 (shorter or longer) produces no write, and the addressed register keeps its old value.
- R4: A read frame produces exactly one single-cycle `reg_rd` pulse, carrying the frame's address, after the seventh bit has been received. The word returned on `miso` has bits 31..24 zero and bits 23..0 equal to the register contents.
- R5: A write frame issues no read strobe and returns an all-zero word on `miso`.
- R6: While select is low, SCK and data-in activity produce no strobe, and `miso` stays 0.
- R7: After reset, `reg_wr`, `reg_rd` and `miso` are 0.
- R8: `reg_rd` and `reg_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Host serial clock, idle low |
| spi_sel | input | 1 | Host select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | DATA_W | Read data, valid while reg_rd is high |

## Verification
The assertions assume the following host behaviour:
- Each SCK phase lasts at least six system clocks.
- Data-in is stable around each rising SCK edge.
- Select is held steady for several clocks before the first and after the last SCK edge.

Under these conditions the synchronised select is still high whenever a strobe derived from an SCK edge appears. The stimulus holds every SCK phase and every select set-up and hold gap for eight system clocks. It changes data-in only while SCK is low, including in the short, overlong and deselected sequences.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int FRAME_W_DEF = 32;
  localparam int ADDR_W_DEF  = 6;
  localparam int DATA_W_DEF  = 24;
  localparam int SYNC_DEF    = 2;
  localparam int MIN_PHASE   = 6;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int WIDTH  = 3,
  parameter int N_EDGE = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  lvl,
  output logic [N_EDGE-1:0] rise,
  output logic [N_EDGE-1:0] fall
);
  logic [WIDTH-1:0]  chain [STAGES];
  logic [N_EDGE-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign lvl = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl[N_EDGE-1:0];
  end

  assign rise = lvl[N_EDGE-1:0] & ~prev;
  assign fall = ~lvl[N_EDGE-1:0] & prev;
endmodule

// File: rtl/spi_regport_rx.sv
module spi_regport_rx #(
  parameter int FRAME_W = 32,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] dat;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hdr     <= '0;
      dat     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (cs_rise) begin
        cnt <= '0;
      end else if (cs_lvl && sck_rise) begin
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        for (int b = 0; b < HDR_W; b++)
          if (cnt == CNT_W'(HDR_W - 1 - b)) hdr[b] <= mosi_s;
        for (int b = 0; b < DATA_W; b++)
          if (cnt == CNT_W'(FRAME_W - 1 - b)) dat[b] <= mosi_s;
        // last address bit arriving on a read frame: fetch now
        if (cnt == CNT_HDR && !hdr[HDR_W-1]) begin
          rd_q   <= 1'b1;
          addr_q <= {hdr[ADDR_W-1:1], mosi_s};
        end
      end
      if (cs_fall && cnt == CNT_FULL && hdr[HDR_W-1]) begin
        wr_q    <= 1'b1;
        addr_q  <= hdr[ADDR_W-1:0];
        wdata_q <= dat;
      end
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;

  // R2
  wr_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(cs_fall));
  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
  // R6
  rd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> cs_lvl);
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx #(
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              sck_fall,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              miso
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0]  fcnt;
  logic [DATA_W-1:0] tx_q;
  logic              bit_c, miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      tx_q <= '0;
    end else begin
      if (cs_rise) begin
        fcnt <= '0;
        tx_q <= '0;
      end else begin
        if (cs_lvl && sck_fall && fcnt != CNT_SAT) fcnt <= fcnt + 1'b1;
        if (reg_rd) tx_q <= reg_rdata;
      end
    end
  end

  // after k falling edges the frame bit FRAME_W-1-k is on the line
  always_comb begin
    bit_c = 1'b0;
    for (int b = 0; b < DATA_W; b++)
      if (fcnt == CNT_W'(FRAME_W - 1 - b)) bit_c = tx_q[b];
    if (!cs_lvl) bit_c = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miso_q <= 1'b0;
    else        miso_q <= bit_c;
  end

  assign miso = miso_q;

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && $past(!cs_lvl)) |=> (miso == 1'b0));
  // R4
  fetch_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (fcnt < CNT_W'(FRAME_W - DATA_W)));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int SYNC_N  = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_sel,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0] s_lvl;
  logic [1:0] s_rise, s_fall;

  spi_regport_sync #(.WIDTH(3), .N_EDGE(2), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_mosi, spi_sel, spi_sck}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  logic rd_int;

  spi_regport_rx #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (s_lvl[1]),
    .cs_rise  (s_rise[1]),
    .cs_fall  (s_fall[1]),
    .sck_rise (s_rise[0]),
    .mosi_s   (s_lvl[2]),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_wr   (reg_wr),
    .reg_rd   (rd_int)
  );

  spi_regport_tx #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (s_lvl[1]),
    .cs_rise  (s_rise[1]),
    .sck_fall (s_fall[0]),
    .reg_rd   (rd_int),
    .reg_rdata(reg_rdata),
    .miso     (spi_miso)
  );

  assign reg_rd = rd_int;
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sel = 1'b0, mosi = 1'b0;
  logic miso;
  logic [5:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic reg_wr, reg_rd;

  always #5 clk = ~clk;

  spi_regport u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sel(sel), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register bank model
  logic [23:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 24'hA50000 | 24'(i);
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;
  assign reg_rdata = mem[reg_addr];

  int wr_cnt = 0, rd_cnt = 0;
  logic [5:0]  last_wa, last_ra;
  logic [23:0] last_wd;
  always @(posedge clk) if (rst_n) begin
    if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
    if (reg_rd) begin rd_cnt++; last_ra = reg_addr; end
  end

  int nvec = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] word, input int nbits, output logic [31:0] rx);
    rx = '0;
    sel = 1'b1;
    clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? word[31-i] : 1'b0;
      clks(HALF);
      sck = 1'b1;
      rx = {rx[30:0], miso};
      clks(HALF);
      sck = 1'b0;
    end
    clks(HALF);
    sel = 1'b0;
    mosi = 1'b0;
    clks(10);
  endtask

  function automatic logic [31:0] frm(input bit w, input logic [5:0] a, input bit pad, input logic [23:0] d);
    return {w, a, pad, d};
  endfunction

  // {frame, expected returned low 24 bits}
  localparam logic [55:0] VEC [10] = '{
    {1'b1, 6'h05, 1'b0, 24'h123456, 24'h000000},
    {1'b0, 6'h05, 1'b0, 24'h000000, 24'h123456},
    {1'b1, 6'h3F, 1'b0, 24'hFFFFFF, 24'h000000},
    {1'b0, 6'h3F, 1'b0, 24'h000000, 24'hFFFFFF},
    {1'b1, 6'h00, 1'b0, 24'h800001, 24'h000000},
    {1'b0, 6'h00, 1'b0, 24'h000000, 24'h800001},
    {1'b0, 6'h2A, 1'b0, 24'h000000, 24'hA5002A},
    {1'b1, 6'h2A, 1'b1, 24'h0F0F0F, 24'h000000},
    {1'b0, 6'h2A, 1'b0, 24'h000000, 24'h0F0F0F},
    {1'b0, 6'h15, 1'b1, 24'h000000, 24'hA50015}
  };

  initial begin
    logic [31:0] rx;
    int w0, r0;
    clks(4);
    // R7: reset state
    chk(reg_wr == 0 && reg_rd == 0 && miso == 0, "R7", {29'd0, reg_wr, reg_rd, miso}, 32'd0);
    rst_n = 1'b1;
    clks(4);
    chk(reg_wr == 0 && reg_rd == 0 && miso == 0, "R7", {29'd0, reg_wr, reg_rd, miso}, 32'd0);

    for (int v = 0; v < 10; v++) begin
      logic [31:0] f;
      logic [23:0] e;
      f = VEC[v][55:24];
      e = VEC[v][23:0];
      w0 = wr_cnt; r0 = rd_cnt;
      xfer(f, 32, rx);
      if (f[31]) begin
        chk(wr_cnt == w0 + 1, "R2", wr_cnt - w0, 1);
        chk(last_wa == f[30:25] && last_wd == f[23:0], "R1", {2'b0, last_wa, last_wd}, {2'b0, f[30:25], f[23:0]});
        chk(rd_cnt == r0, "R5", rd_cnt - r0, 0);
        chk(rx == 32'd0, "R5", rx, 32'd0);
      end else begin
        chk(rd_cnt == r0 + 1 && last_ra == f[30:25], "R4", {last_ra, 26'(rd_cnt - r0)}, {f[30:25], 26'd1});
        chk(rx == {8'h00, e}, "R4", rx, {8'h00, e});
        chk(wr_cnt == w0, "R8", wr_cnt - w0, 0);
      end
    end

    // R3: short write frame discarded
    w0 = wr_cnt;
    xfer(frm(1'b1, 6'h05, 1'b0, 24'hDEADBE), 20, rx);
    chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);
    xfer(frm(1'b0, 6'h05, 1'b0, 24'h0), 32, rx);
    chk(rx == {8'h00, 24'h123456}, "R3", rx, {8'h00, 24'h123456});

    // R3: overlong write frame discarded
    w0 = wr_cnt;
    xfer(frm(1'b1, 6'h05, 1'b0, 24'h0BADF0), 33, rx);
    chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);
    xfer(frm(1'b0, 6'h05, 1'b0, 24'h0), 32, rx);
    chk(rx == {8'h00, 24'h123456}, "R3", rx, {8'h00, 24'h123456});

    // R6: clocking with select low
    w0 = wr_cnt; r0 = rd_cnt;
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 40; i++) begin
        mosi = i[0];
        clks(HALF);
        sck = 1'b1;
        if (miso) hi++;
        clks(HALF);
        sck = 1'b0;
      end
      clks(10);
      chk(hi == 0, "R6", hi, 0);
    end
    chk(wr_cnt == w0 && rd_cnt == r0, "R6", (wr_cnt - w0) + (rd_cnt - r0), 0);
    xfer(frm(1'b0, 6'h3F, 1'b0, 24'h0), 32, rx);
    chk(rx == {8'h00, 24'hFFFFFF}, "R6", rx, {8'h00, 24'hFFFFFF});

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule